// File: doc/BRIEF.md
# RTC Alarm Interrupt Controller

This block watches the calendar fields produced by a timekeeping core (second, minute, hour, weekday, day of month, month) and compares them with two independently programmed alarms. Each alarm holds a value and a compare-enable bit per field. When an alarm's enabled fields first become equal to the current time, the block sets that alarm's status flag. It sets the flag whether or not the alarm is allowed to interrupt.

If an alarm is also unmasked, the same event starts an active-low pulse of fixed length on a single output pin. The pulse length is counted in periods of a 32.768 kHz reference. A mode bit chooses between firing once and firing again on every new match. The same pin can instead carry one of three square waves derived from the reference. While a square wave is selected, no interrupt pulse is started. A host clears both flags with a status-read strobe.

Top module: `rtc_alarm_irq`

## Requirements
- R1: An alarm compares only the fields whose enable bit is set. An alarm with no field enabled never matches. This includes the state after reset, where every alarm register holds zero.
- R2: An alarm event occurs once, in the cycle after the enabled fields become equal. If the fields stay equal, or the time is re-presented unchanged, no further event occurs.
- R3: An event sets the alarm's bit in `alarm_flags` (bit 0 for alarm 0, bit 1 for alarm 1). This happens even when the alarm's interrupt enable is 0. A masked alarm produces no pulse.
- R4: A one-cycle `stat_rd` clears both flags. A flag is never cleared otherwise. When an event and `stat_rd` fall on the same cycle, the flag ends up set.
- R5: With pin select 00, an event from an unmasked, armed alarm drives `irq_freq_pin` low. The pin stays low for PULSE_TICKS rising edges of `ref_in` (default 819, about 25 ms), then returns high.
- R6: With the repeat bit at 0, an alarm pulses at most once after its enable is written through the control register. Later matches still set its flag.
- R7: With the repeat bit at 1, every new match of an unmasked alarm starts a new pulse.
- R8: The pin select (control bits 1:0) chooses the pin output: 00 gives the interrupt, 01 gives 1 Hz (divider bit 14), 10 gives 4096 Hz (divider bit 2), and 11 gives the 32.768 kHz reference itself. While the select is not 00, no pulse is started.
- R9: After reset, `irq_freq_pin` is 1, the flags are 0, and every alarm, mask, mode and select setting is 0.
- R10: Alarm a, field f (0 second, 1 minute, 2 hour, 3 weekday, 4 day of month, 5 month) is written at address 8*a+f. Bits 6:0 hold the value and bit 7 is the field enable. The control register is at address 16: bits 1:0 hold the pin select, bit 2 the repeat bit, and bit 3+a the interrupt enable of alarm a. Writing the control register re-arms the enabled alarms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | 32.768 kHz reference level, synchronised inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| stat_rd | input | 1 | Status-read strobe, clears flags |
| t_sec | input | 7 | Current second |
| t_min | input | 7 | Current minute |
| t_hour | input | 7 | Current hour |
| t_wday | input | 7 | Current weekday |
| t_mday | input | 7 | Current day of month |
| t_mon | input | 7 | Current month |
| alarm_flags | output | 2 | Per-alarm status flags |
| irq_freq_pin | output | 1 | Active-low interrupt pulse or square wave |

## Verification
A vector walk steps the clock through times where alarm 0 matches on the second alone and alarm 1 matches on the minute and hour. These times separate a fresh match from a repeated identical time, one alarm from both at once, and a partial match from a full one. Directed sequences place a status read on the same cycle as an event, and they fire a match with the mask set in one-shot mode and in repeat mode. They also fire a match while a square wave is selected, which shows that no pulse is started. Edge counts over fixed windows tell the three square-wave rates apart.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W    = 7;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int BANK_STRIDE = 8;

  typedef enum logic [1:0] {
    PIN_IRQ   = 2'b00,
    PIN_1HZ   = 2'b01,
    PIN_4KHZ  = 2'b10,
    PIN_32KHZ = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int NA = NUM_ALARMS,
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int STRIDE = BANK_STRIDE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NA*NF*FW-1:0] val,
  output logic [NA*NF-1:0]   fen,
  output pin_sel_e           pin_sel,
  output logic               repeat_mode,
  output logic [NA-1:0]      irq_en,
  output logic               ctrl_wr
);
  localparam int CTRL_ADDR = NA * STRIDE;

  assign ctrl_wr = we && (addr == AW'(CTRL_ADDR));

  // alarm value and per-field enable storage
  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      fen <= '0;
    end else if (we) begin
      for (int a = 0; a < NA; a++) begin
        for (int f = 0; f < NF; f++) begin
          if (addr == AW'(a * STRIDE + f)) begin
            val[(a*NF+f)*FW +: FW] <= wdata[FW-1:0];
            fen[a*NF+f]            <= wdata[DW-1];
          end
        end
      end
    end
  end

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sel     <= PIN_IRQ;
      repeat_mode <= 1'b0;
      irq_en      <= '0;
    end else if (ctrl_wr) begin
      pin_sel     <= pin_sel_e'(wdata[1:0]);
      repeat_mode <= wdata[2];
      irq_en      <= wdata[3 +: NA];
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int NA = NUM_ALARMS,
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NA*NF*FW-1:0] val,
  input  logic [NA*NF-1:0]    fen,
  input  logic [NF*FW-1:0]    tcur,
  output logic [NA-1:0]       evt
);
  logic [NA-1:0] match, match_q;

  for (genvar a = 0; a < NA; a++) begin : g_alarm
    logic [NF-1:0] hit;
    for (genvar f = 0; f < NF; f++) begin : g_field
      assign hit[f] = !fen[a*NF+f] ||
                      (val[(a*NF+f)*FW +: FW] == tcur[f*FW +: FW]);
    end
    assign match[a] = (|fen[a*NF +: NF]) && (&hit);
  end

  // rising-edge detect: one event per new match
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      evt     <= '0;
    end else begin
      match_q <= match;
      evt     <= match & ~match_q;
    end
  end
endmodule

// File: rtl/rtc_ref_div.sv
module rtc_ref_div #(
  parameter int DIV_W   = 15,
  parameter int BIT_1HZ = 14,
  parameter int BIT_4K  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  output logic       ref_rise,
  output logic [2:0] wave
);
  logic s1, s2, s3;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ref_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign ref_rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (ref_rise) cnt <= cnt + 1'b1;
  end

  assign wave[0] = cnt[BIT_1HZ];
  assign wave[1] = cnt[BIT_4K];
  assign wave[2] = s3;
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
  parameter int PULSE_TICKS = 819,
  localparam int CW = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (start)               cnt <= CW'(PULSE_TICKS);
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int NA          = NUM_ALARMS,
  parameter int FW          = FIELD_W,
  parameter int PULSE_TICKS = 819
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          stat_rd,
  input  logic [FW-1:0] t_sec,
  input  logic [FW-1:0] t_min,
  input  logic [FW-1:0] t_hour,
  input  logic [FW-1:0] t_wday,
  input  logic [FW-1:0] t_mday,
  input  logic [FW-1:0] t_mon,
  output logic [NA-1:0] alarm_flags,
  output logic          irq_freq_pin
);
  localparam int NF = NUM_FIELDS;

  logic [NA*NF*FW-1:0] val;
  logic [NA*NF-1:0]    fen;
  pin_sel_e            fo_sel;
  logic                repeat_mode;
  logic [NA-1:0]       irq_en;
  logic                ctrl_wr;
  logic [NA-1:0]       evt;
  logic [NA-1:0]       armed;
  logic [NA-1:0]       fire;
  logic                ref_rise;
  logic [2:0]          wave;
  logic                pulse_busy;
  logic [NF*FW-1:0]    tcur;

  assign tcur = {t_mon, t_mday, t_wday, t_hour, t_min, t_sec};

  rtc_alarm_regs #(.NA(NA), .NF(NF), .FW(FW), .DW(8), .AW(5)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .val(val), .fen(fen), .pin_sel(fo_sel), .repeat_mode(repeat_mode),
    .irq_en(irq_en), .ctrl_wr(ctrl_wr)
  );

  rtc_alarm_match #(.NA(NA), .NF(NF), .FW(FW)) u_match (
    .clk(clk), .rst(rst), .val(val), .fen(fen), .tcur(tcur), .evt(evt)
  );

  rtc_ref_div u_div (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_rise(ref_rise), .wave(wave)
  );

  assign fire = evt & armed & irq_en & {NA{fo_sel == PIN_IRQ}};

  rtc_irq_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .start(|fire), .tick(ref_rise), .busy(pulse_busy)
  );

  // arming: control write arms, one-shot firing disarms
  always_ff @(posedge clk) begin
    if (rst)              armed <= '0;
    else if (ctrl_wr)     armed <= cfg_wdata[3 +: NA];
    else if (!repeat_mode) armed <= armed & ~fire;
  end

  // status flags: set has priority over read-clear
  always_ff @(posedge clk) begin
    if (rst) alarm_flags <= '0;
    else     alarm_flags <= (alarm_flags & ~{NA{stat_rd}}) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_freq_pin <= 1'b1;
    else begin
      unique case (fo_sel)
        PIN_IRQ:   irq_freq_pin <= ~pulse_busy;
        PIN_1HZ:   irq_freq_pin <= wave[0];
        PIN_4KHZ:  irq_freq_pin <= wave[1];
        PIN_32KHZ: irq_freq_pin <= wave[2];
        default:   irq_freq_pin <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int NA = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          stat_rd,
  input logic [NA-1:0] evt,
  input logic [NA-1:0] flags,
  input logic [1:0]    fo_sel,
  input logic          busy,
  input logic          pin
);
  // R9
  reset_state_chk: assert property (@(posedge clk) rst |=> (pin && flags == '0));

  // R8
  no_pulse_in_freq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fo_sel) == 2'b00);

  for (genvar a = 0; a < NA; a++) begin : g_flag
    // R3
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      evt[a] |=> flags[a]);
    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[a]) |-> $past(stat_rd));
    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_rd && !evt[a]) |=> !flags[a]);
  end
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.NA(NA)) u_chk (
  .clk(clk), .rst(rst), .stat_rd(stat_rd), .evt(evt), .flags(alarm_flags),
  .fo_sel(fo_sel), .busy(pulse_busy), .pin(irq_freq_pin)
);

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
  localparam int PT = 819;
  localparam int REFP = 4;

  logic       clk = 1'b0, rst = 1'b1, ref_in = 1'b0;
  logic       cfg_we = 1'b0, stat_rd = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [6:0] t_sec = '0, t_min = '0, t_hour = '0;
  logic [6:0] t_wday = '0, t_mday = '0, t_mon = '0;
  logic [1:0] alarm_flags;
  logic       irq_freq_pin;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always #8 ref_in = ~ref_in;

  rtc_alarm_irq #(.PULSE_TICKS(PT)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .t_sec(t_sec), .t_min(t_min),
    .t_hour(t_hour), .t_wday(t_wday), .t_mday(t_mday), .t_mon(t_mon),
    .alarm_flags(alarm_flags), .irq_freq_pin(irq_freq_pin)
  );

  // {sec, min, hour, exp_flag0, exp_flag1}
  localparam logic [22:0] TBL [8] = '{
    {7'h00, 7'h00, 7'h00, 1'b0, 1'b0},
    {7'h30, 7'h00, 7'h00, 1'b1, 1'b0},
    {7'h30, 7'h00, 7'h00, 1'b0, 1'b0},
    {7'h31, 7'h15, 7'h08, 1'b0, 1'b1},
    {7'h30, 7'h15, 7'h08, 1'b1, 1'b0},
    {7'h30, 7'h15, 7'h09, 1'b0, 1'b0},
    {7'h29, 7'h16, 7'h08, 1'b0, 1'b0},
    {7'h30, 7'h15, 7'h08, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_t(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h);
    @(negedge clk); t_sec = s; t_min = m; t_hour = h;
  endtask

  task automatic clr();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic count_rises(input int n, output int rises, output int edges);
    logic prev;
    prev = irq_freq_pin; rises = 0; edges = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_freq_pin && !prev) rises++;
      if (irq_freq_pin != prev) edges++;
      prev = irq_freq_pin;
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r, e;
    cyc(4); rst = 1'b0; cyc(1);
    chk("R9 pin after reset", irq_freq_pin, 1);
    chk("R9 flags after reset", alarm_flags, 0);
    cyc(8);
    chk("R1 no field enabled never matches", alarm_flags, 0);

    // R10 map: alarm0 sec=30; alarm1 min=15, hour=08
    wr(5'd0, 8'hB0);
    wr(5'd9, 8'h95);
    wr(5'd10, 8'h88);
    wr(5'd1, 8'h44);            // alarm0 minute value without enable: ignored (R1)
    cyc(2); clr();

    for (int i = 0; i < 8; i++) begin
      set_t(TBL[i][22:16], TBL[i][15:9], TBL[i][8:2]);
      cyc(4);
      chk($sformatf("R2 R3 R10 vec%0d flag0", i), alarm_flags[0], TBL[i][1]);
      chk($sformatf("R2 R3 R10 vec%0d flag1", i), alarm_flags[1], TBL[i][0]);
      clr(); cyc(1);
    end
    chk("R3 masked alarm no pulse", irq_freq_pin, 1);
    chk("R4 read clears", alarm_flags, 0);

    // R4 set wins over same-cycle clear
    set_t(7'h00, 7'h00, 7'h00); cyc(3); clr();
    @(negedge clk); t_sec = 7'h30;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R4 set beats clear", alarm_flags[0], 1);
    clr(); cyc(1);
    chk("R4 cleared after read", alarm_flags[0], 0);

    // R5 / R6 one-shot
    set_t(7'h00, 7'h00, 7'h00);
    wr(5'd16, 8'b0000_1000);
    set_t(7'h30, 7'h00, 7'h00); cyc(6);
    chk("R5 pin low on alarm", irq_freq_pin, 0);
    cyc(PT*REFP - 24);
    chk("R5 pin still low near end", irq_freq_pin, 0);
    cyc(48);
    chk("R5 pin released after pulse", irq_freq_pin, 1);
    clr();
    set_t(7'h00, 7'h00, 7'h00); cyc(4);
    set_t(7'h30, 7'h00, 7'h00); cyc(6);
    chk("R6 one-shot no second pulse", irq_freq_pin, 1);
    chk("R6 flag still set", alarm_flags[0], 1);
    clr();

    // R7 repeat mode
    set_t(7'h00, 7'h00, 7'h00);
    wr(5'd16, 8'b0000_1100);
    set_t(7'h30, 7'h00, 7'h00); cyc(6);
    chk("R7 first repeat pulse", irq_freq_pin, 0);
    cyc(PT*REFP + 40);
    set_t(7'h00, 7'h00, 7'h00); cyc(4);
    set_t(7'h30, 7'h00, 7'h00); cyc(6);
    chk("R7 second repeat pulse", irq_freq_pin, 0);
    cyc(PT*REFP + 40);
    chk("R7 pulse ends", irq_freq_pin, 1);

    // R8 no pulse while frequency selected
    set_t(7'h00, 7'h00, 7'h00);
    wr(5'd16, 8'b0000_1111);
    set_t(7'h30, 7'h00, 7'h00); cyc(10);
    wr(5'd16, 8'b0000_1100); cyc(4);
    chk("R8 no pulse under freq select", irq_freq_pin, 1);

    // R8 frequency rates
    wr(5'd16, 8'h02); cyc(8);
    count_rises(3200, r, e);
    chk_rng("R8 4096Hz rises", r, 99, 101);
    wr(5'd16, 8'h03); cyc(8);
    count_rises(3200, r, e);
    chk_rng("R8 32kHz rises", r, 799, 801);
    wr(5'd16, 8'h01); cyc(8);
    count_rises(20000, r, e);
    chk_rng("R8 1Hz edges", e, 0, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule